// File: doc/BRIEF.md
# Per-lane selectable event counter

This block is one event counter for a multi-lane serial link controller. The link logic beside it raises one strobe per lane for each countable event. Software selects an event by group and number, selects one lane, and then starts, stops and clears the count by writing a control word. The counter adds one for every clock cycle in which the selected strobe is high while counting is on. Software reads the running total from a data register on a simple register bus.

Two event groups are implemented. Group 6 holds 7 events, numbered 0 to 6. Group 7 holds 24 events, numbered 0 to 23. An event code is therefore group*0x100 + number. The count is not cleared when the selectors change. Software issues a clear itself, and it can put that clear in the same write that turns counting on.

The run state is held by a two-state machine. `ST_OFF` is the reset state, in which the count is frozen. `ST_ON` is the counting state. The transition `GO` (from `ST_OFF` to `ST_ON`) is taken on an on command. The transition `HALT` (from `ST_ON` to `ST_OFF`) is taken on an off command. Every other write leaves the state where it is.

Top module: `lane_evt_counter`

## Requirements
- R1: After reset the count is 0, the machine is in `ST_OFF`, and a read of the control register returns 0.
- R2: In `ST_ON`, the count rises by exactly one at each clock edge for which the selected strobe was high in the cycle before. No other strobe changes the count. The strobe for event index e on lane l is bit e*LANES+l of `evt_stb`. The event index is the event number for group 6 (0..6), and 7 plus the event number for group 7 (0..23).
- R3: A control write with enable field bits 4:2 = 0x3 takes `GO`, and one with 0x1 takes `HALT`. Any other value leaves the state unchanged. In `ST_OFF` the count holds its value.
- R4: A control write with clear field bits 1:0 = 0x1 sets the count to 0 at that clock edge. Other clear values have no effect. A write that changes only the selectors keeps the count.
- R5: A write that carries both clear and on leaves the count at 0 after its edge, even if the selected strobe was high during the write cycle. Counting starts with the strobe of the next cycle.
- R6: The count wraps modulo 2^CNT_W. CNT_W is 32 by default.
- R7: A group other than 6 or 7, an event number beyond its group's range, or a lane number of LANES or more counts nothing.
- R8: The control register at offset 0x8 reads back the group in bits 27:24, the event number in bits 23:16 and the lane in bits 11:8. Bit 7 reads 1 exactly in `ST_ON`, and writes to bit 7 are ignored.
- R9: A read at offset 0xC returns the current count in the same cycle, with no side effect. Other offsets read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte offset within the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| evt_stb | input | (GRP_A_EVTS+GRP_B_EVTS)*LANES | Per-event, per-lane strobes |

## Verification
A control write and the strobes of the same cycle take effect together at the next rising edge. A read is combinational, so the new count and run state appear at the very next falling edge. The bench drives the bus and the strobes shortly after each falling edge. It samples both registers one time unit after the next falling edge, so it compares against a model that has stepped exactly one edge. The directed sequences settle the expected totals for the R3 stop edge and the R5 clear-with-on edge by counting strobe cycles from that rule.

// File: rtl/lane_evt_pkg.sv
package lane_evt_pkg;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_ON  = 1'b1
    } run_state_e;

    typedef struct packed {
        logic [3:0] grp;
        logic [7:0] evt;
        logic [3:0] lane;
    } evt_sel_t;

    localparam logic [7:0] CTRL_OFS = 8'h08;
    localparam logic [7:0] DATA_OFS = 8'h0C;

    localparam int GRP_HI  = 27;
    localparam int GRP_LO  = 24;
    localparam int EVT_HI  = 23;
    localparam int EVT_LO  = 16;
    localparam int LANE_HI = 11;
    localparam int LANE_LO = 8;
    localparam int STAT_B  = 7;
    localparam int EN_HI   = 4;
    localparam int EN_LO   = 2;
    localparam int CLR_HI  = 1;
    localparam int CLR_LO  = 0;

    localparam logic [2:0] EN_CMD_ON  = 3'h3;
    localparam logic [2:0] EN_CMD_OFF = 3'h1;
    localparam logic [1:0] CLR_CMD    = 2'h1;

endpackage

// File: rtl/lane_evt_regif.sv
module lane_evt_regif
    import lane_evt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              running,
    output evt_sel_t          sel_q,
    output logic              cmd_on,
    output logic              cmd_off,
    output logic              cmd_clr,
    output logic [31:0]       bus_rdata
);

    logic     ctrl_wr;
    logic     hit_ctrl;
    logic     hit_data;
    logic [31:0] ctrl_img;

    assign hit_ctrl = (bus_addr == ADDR_W'(CTRL_OFS));
    assign hit_data = (bus_addr == ADDR_W'(DATA_OFS));
    assign ctrl_wr  = bus_sel && bus_wr && hit_ctrl;

    assign cmd_on  = ctrl_wr && (bus_wdata[EN_HI:EN_LO] == EN_CMD_ON);
    assign cmd_off = ctrl_wr && (bus_wdata[EN_HI:EN_LO] == EN_CMD_OFF);
    assign cmd_clr = ctrl_wr && (bus_wdata[CLR_HI:CLR_LO] == CLR_CMD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (ctrl_wr) begin
            sel_q.grp  <= bus_wdata[GRP_HI:GRP_LO];
            sel_q.evt  <= bus_wdata[EVT_HI:EVT_LO];
            sel_q.lane <= bus_wdata[LANE_HI:LANE_LO];
        end
    end

    always_comb begin
        ctrl_img                  = '0;
        ctrl_img[GRP_HI:GRP_LO]   = sel_q.grp;
        ctrl_img[EVT_HI:EVT_LO]   = sel_q.evt;
        ctrl_img[LANE_HI:LANE_LO] = sel_q.lane;
        ctrl_img[STAT_B]          = running;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (hit_ctrl)
                bus_rdata = ctrl_img;
            else if (hit_data)
                bus_rdata = 32'(cnt);
        end
    end

    // R8: selectors change only through a control write
    a_r8_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(sel_q));

endmodule

// File: rtl/lane_evt_fsm.sv
module lane_evt_fsm
    import lane_evt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_on,
    input  logic cmd_off,
    output logic count_en,
    output logic running
);

    run_state_e state_q;
    run_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_OFF;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: if (cmd_on)  state_d = ST_ON;   // GO
            ST_ON:  if (cmd_off) state_d = ST_OFF;  // HALT
            default: state_d = ST_OFF;
        endcase
    end

    always_comb begin
        count_en = 1'b0;
        running  = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                count_en = 1'b0;
                running  = 1'b0;
            end
            ST_ON: begin
                count_en = 1'b1;
                running  = 1'b1;
            end
            default: begin
                count_en = 1'b0;
                running  = 1'b0;
            end
        endcase
    end

    // R3: the on command leads to counting, the off command stops it
    a_r3_go: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_on |=> running);
    a_r3_halt: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_off |=> !running);

endmodule

// File: rtl/lane_evt_select.sv
module lane_evt_select #(
    parameter int LANES      = 4,
    parameter int GRP_A      = 6,
    parameter int GRP_A_EVTS = 7,
    parameter int GRP_B      = 7,
    parameter int GRP_B_EVTS = 24,
    localparam int NUM_EVT   = GRP_A_EVTS + GRP_B_EVTS,
    localparam int STB_W     = NUM_EVT * LANES
) (
    input  logic [3:0]       sel_grp,
    input  logic [7:0]       sel_evt,
    input  logic [3:0]       sel_lane,
    input  logic [STB_W-1:0] evt_stb,
    output logic             hit
);

    logic [NUM_EVT-1:0] ev_match;
    logic [LANES-1:0]   ln_match;
    logic [STB_W-1:0]   term;

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
        localparam int GC = (i < GRP_A_EVTS) ? GRP_A : GRP_B;
        localparam int NC = (i < GRP_A_EVTS) ? i : i - GRP_A_EVTS;
        assign ev_match[i] = (sel_grp == 4'(GC)) && (sel_evt == 8'(NC));
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign ln_match[l] = (sel_lane == 4'(l));
    end

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_row
        for (genvar l = 0; l < LANES; l++) begin : g_col
            assign term[i*LANES+l] = ev_match[i] & ln_match[l];
        end
    end

    assign hit = |(term & evt_stb);

endmodule

// File: rtl/lane_evt_count.sv
module lane_evt_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + 1'b1;
    end

    // R4: clear wins over any increment
    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
    // R2 and R6: one step per counted strobe, wrapping at the width
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
    // R3: no strobe counted means no change
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !inc) |=> $stable(cnt));

endmodule

// File: rtl/lane_evt_counter.sv
module lane_evt_counter
    import lane_evt_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int GRP_A      = 6,
    parameter int GRP_A_EVTS = 7,
    parameter int GRP_B      = 7,
    parameter int GRP_B_EVTS = 24,
    parameter int CNT_W      = 32,
    parameter int ADDR_W     = 8,
    localparam int STB_W     = (GRP_A_EVTS + GRP_B_EVTS) * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [STB_W-1:0]  evt_stb
);

    evt_sel_t         sel_q;
    logic             cmd_on;
    logic             cmd_off;
    logic             cmd_clr;
    logic             count_en;
    logic             running;
    logic             hit;
    logic [CNT_W-1:0] cnt;

    lane_evt_regif #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cnt       (cnt),
        .running   (running),
        .sel_q     (sel_q),
        .cmd_on    (cmd_on),
        .cmd_off   (cmd_off),
        .cmd_clr   (cmd_clr),
        .bus_rdata (bus_rdata)
    );

    lane_evt_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_on   (cmd_on),
        .cmd_off  (cmd_off),
        .count_en (count_en),
        .running  (running)
    );

    lane_evt_select #(
        .LANES      (LANES),
        .GRP_A      (GRP_A),
        .GRP_A_EVTS (GRP_A_EVTS),
        .GRP_B      (GRP_B),
        .GRP_B_EVTS (GRP_B_EVTS)
    ) u_select (
        .sel_grp  (sel_q.grp),
        .sel_evt  (sel_q.evt),
        .sel_lane (sel_q.lane),
        .evt_stb  (evt_stb),
        .hit      (hit)
    );

    lane_evt_count #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cmd_clr),
        .inc   (count_en & hit),
        .cnt   (cnt)
    );

    // R7: an unimplemented lane never advances the count
    a_r7_lane_range: assert property (@(posedge clk) disable iff (!rst_n)
        ((32'(sel_q.lane) >= LANES) && !cmd_clr) |=> $stable(cnt));

endmodule

// File: tb/lane_evt_counter_tb.sv
module lane_evt_counter_tb;

    localparam int NL = 4;
    localparam int NE = 31;
    localparam int SW = NE * NL;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = 8'h00;
    logic [31:0]   bus_wdata = 32'h0;
    logic [SW-1:0] stb = '0;
    logic [31:0]   rdata;
    logic [31:0]   rdata_n;

    always #5 clk = ~clk;

    lane_evt_counter u_dut (
        .clk (clk), .rst_n (rst_n), .bus_sel (bus_sel), .bus_wr (bus_wr),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (rdata),
        .evt_stb (stb)
    );

    lane_evt_counter #(.CNT_W (8)) u_dut_w8 (
        .clk (clk), .rst_n (rst_n), .bus_sel (bus_sel), .bus_wr (bus_wr),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (rdata_n),
        .evt_stb (stb)
    );

    int checks = 0;
    int errors = 0;

    logic [31:0] m_cnt = '0;
    logic        m_on = 1'b0;
    logic [3:0]  m_grp = '0;
    logic [7:0]  m_evt = '0;
    logic [3:0]  m_lane = '0;
    int          m_idx;

    function automatic int stb_bit(logic [3:0] g, logic [7:0] e, logic [3:0] l);
        int ei;
        ei = -1;
        if (g == 4'd6 && e < 8'd7) ei = int'(e);
        if (g == 4'd7 && e < 8'd24) ei = 7 + int'(e);
        if (l >= 4'(NL)) ei = -1;
        return (ei < 0) ? -1 : ei * NL + int'(l);
    endfunction

    function automatic logic [31:0] mk_ctrl(logic [3:0] g, logic [7:0] e, logic [3:0] l,
                                            logic [2:0] en, logic [1:0] cl);
        return {4'h0, g, e, 4'h0, l, 1'b0, 2'b00, en, cl};
    endfunction

    function automatic logic [SW-1:0] one_bit(int b);
        logic [SW-1:0] v;
        v = '0;
        if (b >= 0) v[b] = 1'b1;
        return v;
    endfunction

    always @(posedge clk) begin
        if (rst_n) begin
            m_idx = stb_bit(m_grp, m_evt, m_lane);
            if (bus_sel && bus_wr && bus_addr == 8'h08 && bus_wdata[1:0] == 2'h1)
                m_cnt = 32'h0;
            else if (m_on && m_idx >= 0 && stb[m_idx])
                m_cnt = m_cnt + 32'h1;
            if (bus_sel && bus_wr && bus_addr == 8'h08) begin
                m_grp  = bus_wdata[27:24];
                m_evt  = bus_wdata[23:16];
                m_lane = bus_wdata[11:8];
                if (bus_wdata[4:2] == 3'h3) m_on = 1'b1;
                if (bus_wdata[4:2] == 3'h1) m_on = 1'b0;
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_now(string tag);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h0C;
        #1;
        chk(tag, rdata, m_cnt);
        chk("R6", rdata_n, {24'h0, m_cnt[7:0]});
        bus_addr = 8'h08;
        #1;
        chk("R8", rdata, {4'h0, m_grp, m_evt, 4'h0, m_lane, m_on, 7'h0});
    endtask

    task automatic cyc(logic w, logic [7:0] a, logic [31:0] wd, logic [SW-1:0] s, string tag);
        @(negedge clk);
        check_now(tag);
        #1;
        bus_wr = w; bus_addr = a; bus_wdata = wd; stb = s;
    endtask

    task automatic peek(logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; stb = '0; bus_addr = a;
        #1;
        v = rdata;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v, v2;
        logic [SW-1:0] tgt;
        int unsigned seed;
        seed = 32'd1234;
        v = $urandom(seed);

        // R1: reset state
        repeat (3) @(negedge clk);
        peek(8'h0C, v); chk("R1", v, 32'h0);
        peek(8'h08, v); chk("R1", v, 32'h0);
        rst_n = 1'b1;
        peek(8'h0C, v); chk("R1", v, 32'h0);

        // R2: group 6 event 2 lane 1 -> bit 9
        tgt = one_bit(stb_bit(4'd6, 8'd2, 4'd1));
        cyc(1'b1, 8'h08, mk_ctrl(4'd6, 8'd2, 4'd1, 3'h3, 2'h1), '0, "R5");
        repeat (10) cyc(1'b0, 8'h08, 32'h0, tgt, "R2");
        peek(8'h0C, v); chk("R2", v, 32'd10);
        repeat (5) cyc(1'b0, 8'h08, 32'h0, ~tgt, "R2");
        peek(8'h0C, v); chk("R2", v, 32'd10);

        // R3: stop edge still counts its own cycle, then holds
        cyc(1'b1, 8'h08, mk_ctrl(4'd6, 8'd2, 4'd1, 3'h1, 2'h0), tgt, "R3");
        repeat (5) cyc(1'b0, 8'h08, 32'h0, tgt, "R3");
        peek(8'h0C, v); chk("R3", v, 32'd11);
        cyc(1'b1, 8'h08, mk_ctrl(4'd6, 8'd2, 4'd1, 3'h2, 2'h0), tgt, "R3");
        repeat (3) cyc(1'b0, 8'h08, 32'h0, tgt, "R3");
        peek(8'h08, v); chk("R3", {31'h0, v[7]}, 32'h0);
        peek(8'h0C, v); chk("R3", v, 32'd11);

        // R4: reselect without clear keeps count; group 7 event 5 lane 2
        tgt = one_bit(stb_bit(4'd7, 8'd5, 4'd2));
        cyc(1'b1, 8'h08, mk_ctrl(4'd7, 8'd5, 4'd2, 3'h3, 2'h0), '0, "R4");
        repeat (3) cyc(1'b0, 8'h08, 32'h0, tgt, "R4");
        peek(8'h0C, v); chk("R4", v, 32'd14);
        cyc(1'b1, 8'h08, mk_ctrl(4'd7, 8'd5, 4'd2, 3'h0, 2'h2), '0, "R4");
        peek(8'h0C, v); chk("R4", v, 32'd14);
        cyc(1'b1, 8'h08, mk_ctrl(4'd7, 8'd5, 4'd2, 3'h0, 2'h1), '0, "R4");
        peek(8'h0C, v); chk("R4", v, 32'd0);

        // R5: clear plus on with the strobe high in the write cycle
        cyc(1'b1, 8'h08, mk_ctrl(4'd7, 8'd5, 4'd2, 3'h3, 2'h1), tgt, "R5");
        peek(8'h0C, v); chk("R5", v, 32'd0);
        cyc(1'b0, 8'h08, 32'h0, tgt, "R5");
        peek(8'h0C, v); chk("R5", v, 32'd1);

        // R7: out-of-range selections
        cyc(1'b1, 8'h08, mk_ctrl(4'd6, 8'd7, 4'd0, 3'h3, 2'h1), '0, "R7");
        repeat (5) cyc(1'b0, 8'h08, 32'h0, '1, "R7");
        peek(8'h0C, v); chk("R7", v, 32'd0);
        cyc(1'b1, 8'h08, mk_ctrl(4'd6, 8'd0, 4'd4, 3'h3, 2'h1), '0, "R7");
        repeat (5) cyc(1'b0, 8'h08, 32'h0, '1, "R7");
        peek(8'h0C, v); chk("R7", v, 32'd0);
        cyc(1'b1, 8'h08, mk_ctrl(4'd5, 8'd0, 4'd0, 3'h3, 2'h1), '0, "R7");
        repeat (5) cyc(1'b0, 8'h08, 32'h0, '1, "R7");
        peek(8'h0C, v); chk("R7", v, 32'd0);
        cyc(1'b1, 8'h08, mk_ctrl(4'd7, 8'd23, 4'd3, 3'h3, 2'h1), '0, "R7");
        repeat (3) cyc(1'b0, 8'h08, 32'h0, '1, "R7");
        peek(8'h0C, v); chk("R7", v, 32'd3);

        // R8: status read-only, readback of fields
        peek(8'h08, v); chk("R8", v, 32'h0717_0380);
        cyc(1'b1, 8'h08, mk_ctrl(4'd7, 8'd23, 4'd3, 3'h1, 2'h0) | 32'h80, '0, "R8");
        peek(8'h08, v); chk("R8", v, 32'h0717_0300);

        // R9: same-cycle reads are equal, stray offsets inert
        @(negedge clk);
        bus_wr = 1'b0; stb = '0; bus_addr = 8'h0C;
        #1 v = rdata;
        #1 v2 = rdata;
        chk("R9", v2, v);
        bus_addr = 8'h10;
        #1 chk("R9", rdata, 32'h0);
        cyc(1'b1, 8'h10, mk_ctrl(4'd6, 8'd0, 4'd0, 3'h3, 2'h1), '0, "R9");
        peek(8'h0C, v); chk("R9", v, 32'd3);
        peek(8'h08, v); chk("R9", v, 32'h0717_0300);

        // R6: wrap of the 8-bit instance, group 7 event 0 lane 0
        tgt = one_bit(stb_bit(4'd7, 8'd0, 4'd0));
        cyc(1'b1, 8'h08, mk_ctrl(4'd7, 8'd0, 4'd0, 3'h3, 2'h1), '0, "R6");
        repeat (300) cyc(1'b0, 8'h08, 32'h0, tgt, "R6");
        peek(8'h0C, v); chk("R6", v, 32'd300);
        chk("R6", rdata_n, 32'd44);

        // R2: random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            logic [SW-1:0] s;
            logic [31:0] wd;
            logic [3:0] g;
            logic w;
            for (int b = 0; b < SW; b++) s[b] = $urandom_range(1, 0) == 1;
            w = ($urandom_range(7, 0) == 0);
            case ($urandom_range(2, 0))
                0: g = 4'd6;
                1: g = 4'd7;
                default: g = 4'd5;
            endcase
            wd = mk_ctrl(g, 8'($urandom_range(25, 0)), 4'($urandom_range(4, 0)),
                         3'($urandom_range(3, 0)), 2'($urandom_range(3, 0)));
            cyc(w, 8'h08, wd, s, "R2");
        end
        cyc(1'b0, 8'h08, 32'h0, '0, "R2");
        @(negedge clk);
        check_now("R2");

        finish_run();
    end

endmodule